// File: doc/BRIEF.md
# Reconfiguration Request Sequencer

This block sits between a group of transceiver channels and a shared reconfiguration controller. Each channel may raise a request, and each request carries a code for the operating mode it wants. The sequencer serves one request at a time. It picks a winner by fixed priority and pulses an acknowledge back to that channel, which then withdraws its request. It then switches the controller port into streaming mode. Next it walks the configuration image for the requested mode word by word, using a valid/ready handshake. It then waits for the controller to report that reconfiguration has finished.

Five images are held, each in its own ROM with a fixed length:
- plain 1G
- plain 10G
- 1G with timestamping
- 10G with timestamping
- the auto-negotiation/link-training image, which puts the channel into a low-latency setting for that phase

Every transaction ends with a one-cycle status pulse. The pulse names the served channel and flags an error in two cases: the mode code was unknown, or completion did not arrive within a bounded wait.

Top module: `reconf_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, ackVec, ctlStreamMode, ctlValid and statusValid are all low.
- R2: When the sequencer is idle and any request is high, exactly one channel receives a one-cycle acknowledge in the next cycle, and that channel is the requesting channel with the lowest index.
- R3: No acknowledge is issued while a transaction is in progress, even when other channels keep requesting.
- R4: After the acknowledge of a supported mode, ctlStreamMode is high for exactly one cycle with ctlValid low, and then the first word (address 0) is presented.
- R5: Each image word is presented with ctlValid high and ctlChannel equal to the winner. The word on ctlAddr and ctlData stays unchanged until a cycle with ctlReady high, and the addresses run 0, 1, 2 and so on, each once.
- R6: Mode codes and image lengths are: 0 = 1G (5 words), 1 = 10G (6), 2 = 1G timestamped (7), 3 = 10G timestamped (8), 4 = auto-negotiation/link-training (4). The word at address a of mode m is ((m+1)*4096) XOR (29*a + 5*m + 3), in 16 bits.
- R7: A request with mode code 5, 6 or 7 is acknowledged, no word is streamed, ctlStreamMode stays low, and in the cycle after the acknowledge a status pulse with statusErr high is given.
- R8: After the last word is accepted, ctlValid is low and ctlStreamMode stays high until ctlDone is seen. The status pulse follows in the next cycle, with statusErr low.
- R9: If ctlDone is not seen during the first TIMEOUT_CYC wait cycles, the status pulse follows with statusErr high. A ctlDone in the final wait cycle still counts as success.
- R10: The status pulse lasts one cycle, carries the served channel on statusCh, and is never high together with ctlStreamMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqVec | input | NUM_CH | Per-channel reconfiguration request |
| reqMode | input | NUM_CH*MODE_W | Requested mode code per channel, channel i in bits [i*MODE_W +: MODE_W] |
| ackVec | output | NUM_CH | One-cycle acknowledge to the winning channel |
| ctlStreamMode | output | 1 | Puts the reconfiguration controller in streaming mode |
| ctlChannel | output | CH_W | Target channel of the stream |
| ctlValid | output | 1 | Image word valid |
| ctlAddr | output | ADDR_W | Image word address |
| ctlData | output | DATA_W | Image word |
| ctlReady | input | 1 | Controller accepts the current word |
| ctlDone | input | 1 | Controller reports reconfiguration finished |
| statusValid | output | 1 | One-cycle completion status pulse |
| statusErr | output | 1 | Error flag qualified by statusValid |
| statusCh | output | CH_W | Channel the status refers to |

## Verification
The acknowledge is due one clock after requests are applied to an idle sequencer. The streaming-mode-only cycle follows one clock later, and the first word one clock after that. Each further word appears one clock after a word has been accepted. The status pulse is due one clock after ctlDone, after TIMEOUT_CYC wait cycles on a timeout, or one clock after the acknowledge for an unknown mode. The bench drives inputs and samples outputs on the falling edge. It walks one cycle at a time through each of these phases and compares every cycle against its own model of the winner, the image length and the word formula.

// File: rtl/reconf_seq_pkg.sv
package reconf_seq_pkg;

  localparam int NUM_IMAGES = 5;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_GRANT     = 3'd1,
    S_SET_MODE  = 3'd2,
    S_STREAM    = 3'd3,
    S_WAIT_DONE = 3'd4,
    S_REPORT    = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchGrant;
    logic clrCnt;
    logic incCnt;
    logic clrTmr;
    logic incTmr;
    logic showAck;
    logic showValid;
    logic streamOn;
    logic showStatus;
  } ctlStrobes_t;

  // flags from datapath to control
  typedef struct packed {
    logic anyReq;
    logic modeOk;
    logic lastWord;
    logic timedOut;
  } dpFlags_t;

  // word count of each configuration image
  function automatic int imgLen(input int modeId);
    case (modeId)
      0:       return 5;
      1:       return 6;
      2:       return 7;
      3:       return 8;
      4:       return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/reconf_rom.sv
module reconf_rom #(
  parameter int MODE_ID = 0,
  parameter int LEN     = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int BASE = (MODE_ID + 1) << (DATA_W - 4);

  always_comb begin
    if (int'(addr) < LEN)
      data = DATA_W'(BASE) ^ DATA_W'(int'(addr) * 29 + MODE_ID * 5 + 3);
    else
      data = '0;
  end
endmodule

// File: rtl/reconf_ctrl.sv
module reconf_ctrl
  import reconf_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpFlags_t    flags,
  input  logic        ctlReady,
  input  logic        ctlDone,
  output ctlStrobes_t strobes,
  output logic        statusValid,
  output logic        statusErr
);
  seqState_t state, stateNext;
  logic errReg, setErr, clrErr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      errReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (setErr)      errReg <= 1'b1;
      else if (clrErr) errReg <= 1'b0;
    end
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    setErr    = 1'b0;
    clrErr    = 1'b0;
    strobes.showAck    = (state == S_GRANT);
    strobes.showValid  = (state == S_STREAM);
    strobes.streamOn   = (state == S_SET_MODE) || (state == S_STREAM) ||
                         (state == S_WAIT_DONE);
    strobes.showStatus = (state == S_REPORT);
    case (state)
      S_IDLE: begin
        if (flags.anyReq) begin
          strobes.latchGrant = 1'b1;
          stateNext = S_GRANT;
        end
      end
      S_GRANT: begin
        if (flags.modeOk) begin
          strobes.clrCnt = 1'b1;
          stateNext = S_SET_MODE;
        end else begin
          setErr = 1'b1;
          stateNext = S_REPORT;
        end
      end
      S_SET_MODE: stateNext = S_STREAM;
      S_STREAM: begin
        if (ctlReady) begin
          if (flags.lastWord) begin
            strobes.clrTmr = 1'b1;
            stateNext = S_WAIT_DONE;
          end else begin
            strobes.incCnt = 1'b1;
          end
        end
      end
      S_WAIT_DONE: begin
        if (ctlDone) begin
          clrErr = 1'b1;
          stateNext = S_REPORT;
        end else if (flags.timedOut) begin
          setErr = 1'b1;
          stateNext = S_REPORT;
        end else begin
          strobes.incTmr = 1'b1;
        end
      end
      S_REPORT: stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  assign statusValid = (state == S_REPORT);
  assign statusErr   = (state == S_REPORT) && errReg;
endmodule

// File: rtl/reconf_dpath.sv
module reconf_dpath
  import reconf_seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int MODE_W      = 3,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int TIMEOUT_CYC = 40,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TMR_W      = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        reqVec,
  input  logic [NUM_CH*MODE_W-1:0] reqMode,
  input  ctlStrobes_t              strobes,
  output dpFlags_t                 flags,
  output logic [NUM_CH-1:0]        ackVec,
  output logic [CH_W-1:0]          ctlChannel,
  output logic [ADDR_W-1:0]        ctlAddr,
  output logic [DATA_W-1:0]        ctlData,
  output logic [CH_W-1:0]          statusCh
);
  logic [CH_W-1:0]   reqWin, winIdx;
  logic [MODE_W-1:0] winMode;
  logic [ADDR_W-1:0] cnt, lastIdx;
  logic [TMR_W-1:0]  tmr;
  logic [DATA_W-1:0] romOut [NUM_IMAGES];
  logic [DATA_W-1:0] romSel;
  logic              found;

  // fixed priority: lowest index wins
  always_comb begin
    reqWin = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reqVec[i] && !found) begin
        reqWin = CH_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winIdx  <= '0;
      winMode <= '0;
      cnt     <= '0;
      tmr     <= '0;
    end else begin
      if (strobes.latchGrant) begin
        winIdx  <= reqWin;
        winMode <= reqMode[reqWin*MODE_W +: MODE_W];
      end
      if (strobes.clrCnt)      cnt <= '0;
      else if (strobes.incCnt) cnt <= cnt + 1'b1;
      if (strobes.clrTmr)      tmr <= '0;
      else if (strobes.incTmr) tmr <= tmr + 1'b1;
    end
  end

  // one ROM per image
  for (genvar g = 0; g < NUM_IMAGES; g++) begin : g_rom
    reconf_rom #(
      .MODE_ID(g),
      .LEN    (imgLen(g)),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) i_rom (
      .addr(cnt),
      .data(romOut[g])
    );
  end

  always_comb begin
    romSel  = '0;
    lastIdx = '0;
    for (int k = 0; k < NUM_IMAGES; k++) begin
      if (winMode == MODE_W'(k)) begin
        romSel  = romOut[k];
        lastIdx = ADDR_W'(imgLen(k) - 1);
      end
    end
  end

  assign flags.anyReq   = |reqVec;
  assign flags.modeOk   = (int'(winMode) < NUM_IMAGES);
  assign flags.lastWord = (cnt == lastIdx);
  assign flags.timedOut = (tmr == TMR_W'(TIMEOUT_CYC - 1));

  assign ackVec     = strobes.showAck ? (NUM_CH'(1) << winIdx) : '0;
  assign ctlChannel = strobes.streamOn ? winIdx : '0;
  assign ctlAddr    = strobes.showValid ? cnt : '0;
  assign ctlData    = strobes.showValid ? romSel : '0;
  assign statusCh   = strobes.showStatus ? winIdx : '0;
endmodule

// File: rtl/reconf_sequencer.sv
module reconf_sequencer
  import reconf_seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int MODE_W      = 3,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int TIMEOUT_CYC = 40,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        reqVec,
  input  logic [NUM_CH*MODE_W-1:0] reqMode,
  output logic [NUM_CH-1:0]        ackVec,
  output logic                     ctlStreamMode,
  output logic [CH_W-1:0]          ctlChannel,
  output logic                     ctlValid,
  output logic [ADDR_W-1:0]        ctlAddr,
  output logic [DATA_W-1:0]        ctlData,
  input  logic                     ctlReady,
  input  logic                     ctlDone,
  output logic                     statusValid,
  output logic                     statusErr,
  output logic [CH_W-1:0]          statusCh
);
  ctlStrobes_t strobes;
  dpFlags_t    flags;

  reconf_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .flags      (flags),
    .ctlReady   (ctlReady),
    .ctlDone    (ctlDone),
    .strobes    (strobes),
    .statusValid(statusValid),
    .statusErr  (statusErr)
  );

  reconf_dpath #(
    .NUM_CH     (NUM_CH),
    .MODE_W     (MODE_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .reqVec    (reqVec),
    .reqMode   (reqMode),
    .strobes   (strobes),
    .flags     (flags),
    .ackVec    (ackVec),
    .ctlChannel(ctlChannel),
    .ctlAddr   (ctlAddr),
    .ctlData   (ctlData),
    .statusCh  (statusCh)
  );

  assign ctlStreamMode = strobes.streamOn;
  assign ctlValid      = strobes.showValid;
endmodule

// File: rtl/reconf_sequencer_chk.sv
module reconf_sequencer_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ackVec,
  input logic              ctlStreamMode,
  input logic              ctlValid,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic [DATA_W-1:0] ctlData,
  input logic              ctlReady,
  input logic              statusValid
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (ackVec == '0) && !ctlStreamMode && !ctlValid && !statusValid);

  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ackVec));

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (ackVec != '0) |=> (ackVec == '0));

  p_no_ack_busy_r3: assert property (@(posedge clk) disable iff (rst)
    ctlStreamMode |-> (ackVec == '0));

  p_first_word_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ctlValid) |-> (ctlAddr == '0) && $past(ctlStreamMode));

  p_hold_word_r5: assert property (@(posedge clk) disable iff (rst)
    (ctlValid && !ctlReady) |=> ctlValid && $stable(ctlAddr) && $stable(ctlData));

  p_valid_in_mode_r5: assert property (@(posedge clk) disable iff (rst)
    ctlValid |-> ctlStreamMode);

  p_status_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    statusValid |=> !statusValid);

  p_status_apart_r10: assert property (@(posedge clk) disable iff (rst)
    statusValid |-> !ctlStreamMode);
endmodule

bind reconf_sequencer reconf_sequencer_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .ackVec       (ackVec),
  .ctlStreamMode(ctlStreamMode),
  .ctlValid     (ctlValid),
  .ctlAddr      (ctlAddr),
  .ctlData      (ctlData),
  .ctlReady     (ctlReady),
  .statusValid  (statusValid)
);

// File: tb/test_reconf_sequencer.sv
module test_reconf_sequencer;
  localparam int NUM_CH = 4;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int TO_CYC = 40;
  localparam int CH_W   = 2;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [NUM_CH-1:0]        reqVec = '0;
  logic [NUM_CH*MODE_W-1:0] reqMode = '0;
  logic [NUM_CH-1:0]        ackVec;
  logic                     ctlStreamMode, ctlValid, ctlReady = 1'b0, ctlDone = 1'b0;
  logic [CH_W-1:0]          ctlChannel, statusCh;
  logic [ADDR_W-1:0]        ctlAddr;
  logic [DATA_W-1:0]        ctlData;
  logic                     statusValid, statusErr;

  int nTests = 0;
  int nFail  = 0;

  reconf_sequencer i_reconf_sequencer (
    .clk(clk), .rst(rst), .reqVec(reqVec), .reqMode(reqMode), .ackVec(ackVec),
    .ctlStreamMode(ctlStreamMode), .ctlChannel(ctlChannel), .ctlValid(ctlValid),
    .ctlAddr(ctlAddr), .ctlData(ctlData), .ctlReady(ctlReady), .ctlDone(ctlDone),
    .statusValid(statusValid), .statusErr(statusErr), .statusCh(statusCh)
  );

  always #10 clk = ~clk;

  function automatic int expLen(input int m);
    case (m)
      0: return 5; 1: return 6; 2: return 7; 3: return 8; 4: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] expWord(input int m, input int a);
    return 16'((m + 1) * 4096) ^ 16'(29 * a + 5 * m + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one full transaction; dly < 0 means ctlDone never comes
  task automatic runTxn(input logic [NUM_CH-1:0] reqs, input logic [NUM_CH*MODE_W-1:0] modes,
                        input int dly);
    int win = 0;
    int m;
    int idx;
    bit expErr;
    for (int i = NUM_CH - 1; i >= 0; i--) if (reqs[i]) win = i;
    m = int'(modes[win*MODE_W +: MODE_W]);
    reqVec  = reqs;
    reqMode = modes;
    @(negedge clk);
    chk(ackVec == NUM_CH'(1 << win), "R2 ack to lowest requester", ackVec, 1 << win);
    chk(!ctlStreamMode, "R7/R4 no stream mode during grant", ctlStreamMode, 0);
    reqVec[win] = 1'b0;
    if (m >= 5) begin
      @(negedge clk);
      chk(statusValid && statusErr, "R7 unknown mode error status", {statusValid, statusErr}, 3);
      chk(statusCh == CH_W'(win), "R10 status channel", statusCh, win);
      chk(!ctlStreamMode && !ctlValid, "R7 nothing streamed", {ctlStreamMode, ctlValid}, 0);
      chk(ackVec == '0, "R3 no ack while busy", ackVec, 0);
      reqVec = '0;
      @(negedge clk);
      chk(!statusValid, "R10 status one cycle", statusValid, 0);
      return;
    end
    @(negedge clk);
    chk(ctlStreamMode && !ctlValid, "R4 stream mode set before data", {ctlStreamMode, ctlValid}, 2);
    chk(ackVec == '0, "R3 no ack while busy", ackVec, 0);
    @(negedge clk);
    idx = 0;
    while (idx < expLen(m)) begin
      chk(ctlValid && ctlStreamMode, "R5 word valid", {ctlValid, ctlStreamMode}, 3);
      chk(ctlAddr == ADDR_W'(idx), "R5 address order", ctlAddr, idx);
      chk(ctlData == expWord(m, idx), "R6 image word", ctlData, expWord(m, idx));
      chk(ctlChannel == CH_W'(win), "R5 target channel", ctlChannel, win);
      chk(ackVec == '0, "R3 no ack while busy", ackVec, 0);
      ctlReady = ($urandom % 3) != 0;
      if (ctlReady) idx++;
      @(negedge clk);
    end
    ctlReady = 1'b0;
    expErr = !(dly >= 0 && dly <= TO_CYC - 1);
    for (int w = 0; ; w++) begin
      chk(ctlStreamMode && !ctlValid && !statusValid, "R8 waiting for done",
          {ctlStreamMode, ctlValid, statusValid}, 4);
      ctlDone = (w == dly);
      @(negedge clk);
      ctlDone = 1'b0;
      if (w == dly || w == TO_CYC - 1) break;
    end
    chk(statusValid, "R8 status after done or timeout", statusValid, 1);
    chk(statusErr == expErr, "R9 status error flag", statusErr, expErr);
    chk(statusCh == CH_W'(win), "R10 status channel", statusCh, win);
    chk(!ctlStreamMode, "R10 stream mode off in status", ctlStreamMode, 0);
    reqVec = '0;
    @(negedge clk);
    chk(!statusValid && ackVec == '0, "R10 status one cycle", {statusValid, ackVec}, 0);
  endtask

  function automatic logic [NUM_CH*MODE_W-1:0] allMode(input int m);
    logic [NUM_CH*MODE_W-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i*MODE_W +: MODE_W] = MODE_W'(m);
    return v;
  endfunction

  initial begin
    int wd;
    for (wd = 0; wd < 100000; wd++) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ackVec == '0 && !ctlStreamMode && !ctlValid && !statusValid, "R1 outputs in reset",
        {ackVec, ctlStreamMode, ctlValid, statusValid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ackVec == '0 && !ctlStreamMode && !ctlValid && !statusValid, "R1 outputs after reset",
        {ackVec, ctlStreamMode, ctlValid, statusValid}, 0);
    // directed: every mode on channel 0, all channels requesting
    for (int m = 0; m < 5; m++) runTxn(4'b1111, allMode(m), 3);
    // only highest channel
    runTxn(4'b1000, allMode(4), 0);
    // unknown mode codes
    runTxn(4'b0100, allMode(7), 0);
    runTxn(4'b0110, allMode(5), 0);
    // done on the last wait cycle, and one cycle too late
    runTxn(4'b0010, allMode(1), TO_CYC - 1);
    runTxn(4'b0001, allMode(2), TO_CYC);
    runTxn(4'b1010, allMode(3), -1);
    // random transactions
    for (int t = 0; t < 30; t++) begin
      logic [NUM_CH-1:0] r;
      logic [NUM_CH*MODE_W-1:0] md;
      int d;
      r  = NUM_CH'($urandom % 15 + 1);
      md = (NUM_CH*MODE_W)'($urandom);
      d  = (($urandom % 6) == 0) ? -1 : int'($urandom % 12);
      runTxn(r, md, d);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule